// File: doc/BRIEF.md
# Flash Erase Block Guard

This block holds the erase-block selection for a 128 KB on-chip flash and screens every erase request against it. Software writes an 8-bit selection value with one bit per erase block. An erase request carries a 17-bit flash byte address and a strobe. One cycle later the guard returns either a grant or a protection fault. A grant is given only if the address falls in the one block whose selection bit is set.

The eight blocks differ in size. The lower flash is split into three 32 KB blocks and one 28 KB block. The top 4 KB is split into four 1 KB blocks. Several conditions force the selection back to zero: the power-saving standby states, a low flash write-enable pin, and a clear software write-enable bit. While the flash is disabled, the selection cannot be written and reads as zero.

Top module: `flash_erase_guard`

## Requirements
- R1: After `rst_n` goes low, the selection is 0x00. `reg_rdata` reads 0x00, and every erase request faults until a block is selected.
- R2: The selection is cleared to 0x00 at the clock edge where any of these is true: `hw_standby` is high, `sw_standby` is high, `wen_pin` is low, or `sw_wen` is low. This clear overrides a register write made in the same cycle.
- R3: A write (`reg_we` high, flash enabled, no clear condition) loads `reg_wdata` at the next edge only when at most one bit is set. A value with two or more bits set is dropped, and the previous selection stays.
- R4: Writing 0x00 is a legal write. It clears the selection, and all later erase requests fault.
- R5: While `flash_on` is low, `reg_rdata` reads 0x00 and writes are ignored. The stored selection is kept, and it reads back once `flash_on` returns high.
- R6: Bit i of the selection allows erasing block i, and no other block. Blocks 0, 1 and 2 start at 0x00000, 0x08000 and 0x10000 and are 32 KB each. Block 3 covers 0x18000 to 0x1EFFF. Blocks 4, 5, 6 and 7 are 1 KB each and start at 0x1F000, 0x1F400, 0x1F800 and 0x1FC00.
- R7: Each cycle with `erase_req` high produces exactly one of `erase_grant` or `erase_fault` in the following cycle. Both outputs stay low in the cycle after a cycle with no request.
- R8: A request made while a clear condition of R2 holds, or while `flash_on` is low, always faults.
- R9: `reg_rdata` shows the stored selection in the same cycle, with no added delay, whenever `flash_on` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_standby | input | 1 | Hardware standby active |
| sw_standby | input | 1 | Software standby active |
| wen_pin | input | 1 | Flash write-enable pin level |
| sw_wen | input | 1 | Software write-enable bit |
| flash_on | input | 1 | On-chip flash enabled |
| reg_we | input | 1 | Selection register write strobe |
| reg_wdata | input | 8 | Selection write data, bit i = block i |
| reg_rdata | output | 8 | Selection read data |
| erase_req | input | 1 | Erase request strobe |
| erase_addr | input | 17 | Flash byte address of the erase request |
| erase_grant | output | 1 | Request allowed, one cycle after the strobe |
| erase_fault | output | 1 | Request blocked, one cycle after the strobe |

## Verification
Three kinds of wrong internal state can occur. A bad selection would be a multi-bit value, a value left over after a clear, or a write that should have been dropped. A bad selection shows on `reg_rdata` at the first falling edge after the clock edge that stored it. It also flips the next grant or fault for an address in the affected block. A wrong block decode shows only at an address in the mis-mapped range, so the bench probes both ends of every block and both sides of the 28 KB/1 KB boundary. Lost or duplicated results show one cycle after the strobe, when the scoreboard queue finds a result with no matching request, or a request with no result.

// File: rtl/flash_erase_guard.sv
`timescale 1ns/1ps
module flash_erase_guard #(
  parameter int NBLK = 8,
  parameter int AW   = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_standby,
  input  logic            sw_standby,
  input  logic            wen_pin,
  input  logic            sw_wen,
  input  logic            flash_on,
  input  logic            reg_we,
  input  logic [NBLK-1:0] reg_wdata,
  output logic [NBLK-1:0] reg_rdata,
  input  logic            erase_req,
  input  logic [AW-1:0]   erase_addr,
  output logic            erase_grant,
  output logic            erase_fault
);
  localparam int EW = AW + 1;

  function automatic logic [EW-1:0] blk_base(input int i);
    case (i)
      0:       return EW'('h00000);
      1:       return EW'('h08000);
      2:       return EW'('h10000);
      3:       return EW'('h18000);
      4:       return EW'('h1F000);
      5:       return EW'('h1F400);
      6:       return EW'('h1F800);
      7:       return EW'('h1FC00);
      default: return EW'('h20000);
    endcase
  endfunction

  logic [NBLK-1:0] sel_q;
  logic [NBLK-1:0] hit;
  logic            clr, wr_ok, allow;
  logic            grant_q, fault_q;
  logic [EW-1:0]   addr_x;

  assign clr    = hw_standby | sw_standby | ~wen_pin | ~sw_wen;
  assign wr_ok  = reg_we & flash_on & ~clr & ((reg_wdata & (reg_wdata - 1'b1)) == '0);
  assign addr_x = {1'b0, erase_addr};

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    assign hit[i] = (addr_x >= blk_base(i)) && (addr_x < blk_base(i + 1));
  end

  assign allow     = flash_on & ~clr & |(hit & sel_q);
  assign reg_rdata = flash_on ? sel_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (clr)   sel_q <= '0;
    else if (wr_ok) sel_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      grant_q <= erase_req & allow;
      fault_q <= erase_req & ~allow;
    end
  end

  assign erase_grant = grant_q;
  assign erase_fault = fault_q;
endmodule

module flash_erase_guard_chk #(
  parameter int NBLK = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hw_standby,
  input logic            sw_standby,
  input logic            wen_pin,
  input logic            sw_wen,
  input logic            flash_on,
  input logic            reg_we,
  input logic [NBLK-1:0] reg_wdata,
  input logic [NBLK-1:0] reg_rdata,
  input logic [NBLK-1:0] sel,
  input logic            erase_req,
  input logic            erase_grant,
  input logic            erase_fault
);
  logic clr_c;
  assign clr_c = hw_standby || sw_standby || !wen_pin || !sw_wen;

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_c |=> (sel == '0));
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  p_multi_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !clr_c && $countones(reg_wdata) > 1) |=> $stable(sel));
  p_off_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_on && !clr_c) |=> $stable(sel));
  p_grant_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_grant |-> ($past(sel) != '0));
  p_one_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> (erase_grant != erase_fault));
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_req |=> (!erase_grant && !erase_fault));
  p_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && (clr_c || !flash_on)) |=> erase_fault);
  p_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flash_on |-> (reg_rdata == sel));
endmodule

bind flash_erase_guard flash_erase_guard_chk #(.NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .sw_standby(sw_standby),
  .wen_pin(wen_pin), .sw_wen(sw_wen), .flash_on(flash_on), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sel(sel_q),
  .erase_req(erase_req), .erase_grant(erase_grant), .erase_fault(erase_fault)
);

// File: tb/flash_erase_guard_bench.sv
`timescale 1ns/1ps
module flash_erase_guard_bench;
  logic clk = 0, rst_n = 0;
  logic hw_standby = 0, sw_standby = 0, wen_pin = 1, sw_wen = 1, flash_on = 1;
  logic reg_we = 0, erase_req = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [16:0] erase_addr = 0;
  logic erase_grant, erase_fault;
  int compared = 0, mismatched = 0;

  typedef struct { logic g; logic [16:0] a; string tag; } exp_t;
  exp_t q[$];
  logic [7:0] m_sel = 0;
  logic [17:0] base [0:8] = '{18'h00000, 18'h08000, 18'h10000, 18'h18000,
                              18'h1F000, 18'h1F400, 18'h1F800, 18'h1FC00, 18'h20000};

  always #5 clk = ~clk;

  flash_erase_guard u_flash_erase_guard (.*);

  function automatic int blk_of(input logic [16:0] a);
    for (int i = 7; i >= 0; i--) if ({1'b0, a} >= base[i]) return i;
    return 0;
  endfunction

  function automatic logic clr_now();
    return hw_standby | sw_standby | !wen_pin | !sw_wen;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_sel = 0;
    else if (clr_now()) m_sel = 0;
    else if (reg_we && flash_on && $countones(reg_wdata) <= 1) m_sel = reg_wdata;
  end

  always @(posedge clk) begin
    logic p;
    p = erase_req;
    #1;
    if (p) begin
      compared++;
      if (q.size() == 0) begin
        mismatched++;
        $display("FAIL R7: result with no queued request grant=%b fault=%b", erase_grant, erase_fault);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (erase_grant !== e.g || erase_fault !== !e.g) begin
          mismatched++;
          $display("FAIL %s addr=%h: grant/fault=%b%b expected %b%b", e.tag, e.a,
                   erase_grant, erase_fault, e.g, !e.g);
        end
      end
    end else if (rst_n && (erase_grant || erase_fault)) begin
      compared++; mismatched++;
      $display("FAIL R7: spurious result grant=%b fault=%b expected 00", erase_grant, erase_fault);
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic req(input logic [16:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    e.a = a; e.tag = tag;
    e.g = flash_on && !clr_now() && m_sel[blk_of(a)];
    q.push_back(e);
    erase_req = 1; erase_addr = a;
    @(negedge clk); erase_req = 0;
  endtask

  task automatic chk_rd(input logic [7:0] exp, input string tag);
    compared++;
    if (reg_rdata !== exp) begin
      mismatched++;
      $display("FAIL %s: reg_rdata=%h expected %h", tag, reg_rdata, exp);
    end
  endtask

  initial begin
    #500000;
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_rd(8'h00, "R1 reset value");
    req(17'h00000, "R1 fault after reset");

    for (int i = 0; i < 8; i++) begin
      wr(8'(1 << i));
      chk_rd(8'(1 << i), "R3 one-hot write");
      req(base[i][16:0], "R6 block low end");
      req(17'(base[i + 1] - 1), "R6 block high end");
      req(base[(i + 1) % 8][16:0], "R6 other block");
    end

    wr(8'h08);
    req(17'h1EFFF, "R6 block 3 top");
    req(17'h1F000, "R6 block 4 bottom vs sel 3");
    wr(8'h10);
    req(17'h1EFFF, "R6 block 3 top vs sel 4");
    req(17'h1F000, "R6 block 4 bottom");
    req(17'h1F3FF, "R6 block 4 top");
    req(17'h1F400, "R6 block 5 vs sel 4");

    wr(8'h03);
    chk_rd(8'h10, "R3 multi-bit write dropped");
    req(17'h00000, "R3 block 0 after dropped write");
    wr(8'hFF);
    chk_rd(8'h10, "R3 all-ones dropped");

    @(negedge clk); erase_req = 1; erase_addr = 17'h1F100;
    q.push_back('{g: 1'b1, a: 17'h1F100, tag: "R7 back-to-back first"});
    @(negedge clk); erase_addr = 17'h00100;
    q.push_back('{g: 1'b0, a: 17'h00100, tag: "R7 back-to-back second"});
    @(negedge clk); erase_req = 0;

    wr(8'h00);
    chk_rd(8'h00, "R4 zero write");
    req(17'h1F000, "R4 fault after zero write");

    for (int c = 0; c < 4; c++) begin
      wr(8'h01);
      @(negedge clk);
      case (c)
        0: hw_standby = 1;
        1: sw_standby = 1;
        2: wen_pin = 0;
        default: sw_wen = 0;
      endcase
      req(17'h00010, "R8 request under clear");
      chk_rd(8'h00, "R2 forced clear");
      wr(8'h02);
      chk_rd(8'h00, "R2 clear beats write");
      hw_standby = 0; sw_standby = 0; wen_pin = 1; sw_wen = 1;
      @(negedge clk);
      chk_rd(8'h00, "R2 stays clear after release");
    end

    wr(8'h04);
    @(negedge clk); flash_on = 0;
    #1 chk_rd(8'h00, "R5 read while disabled");
    req(17'h10000, "R8 request while disabled");
    wr(8'h01);
    @(negedge clk); flash_on = 1;
    #1 chk_rd(8'h04, "R5 write ignored while disabled");
    req(17'h10000, "R6 grant after re-enable");

    @(negedge clk); reg_we = 1; reg_wdata = 8'h20;
    #1 chk_rd(8'h04, "R9 read before write edge");
    @(negedge clk); reg_we = 0;
    chk_rd(8'h20, "R9 read right after write edge");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL R7: %0d results missing, expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule